// File: doc/BRIEF.md
# Loop Current Target Control

This block sits between the register file of a current-loop output converter and its DAC core. It takes the committed data word, the three-bit range selector, the output-enable bit and an asynchronous active-high clear request. From these it produces the code the converter core should hold, the range the output stage should use, a drive-enable flag with its high-impedance complement, and the nominal loop current in microamps for that code.

A clear request is first brought into the system clock domain and must then stay high for a minimum number of clocks, so that short spikes are rejected. Once qualified, the clear forces the target code to zero, which is the bottom of whichever range is selected. The cleared code stays after the request drops. Data commits are refused while the clear is qualified. After release, a latch strobe that carried no new data brings back the code that was in force before the clear, and a fresh data commit installs its own value instead.

Top module: `loop_target_ctrl`

## Requirements
- R1: While `rst` is high and after it drops with no other stimulus, `target_code` is 0, `range_code` is 0, `drive_en` is 0, `out_hiz` is 1 and `iout_ua` is 0.
- R2: With no qualified clear, a one-cycle `data_commit` makes `target_code` equal to `data_word` from the clock edge that samples the strobe.
- R3: `range_code` follows `range_sel` one clock later. Valid codes are 3'b101 (4 to 20 mA), 3'b110 (0 to 20 mA) and 3'b111 (0 to 24 mA); `drive_en` is `out_en` AND a valid code, `out_hiz` is its inverse, and any other code keeps the output off whatever `out_en` says.
- R4: With `drive_en` high, `iout_ua` = floor + (span × `target_code`) >> CODE_W, where span is 16000, 20000 or 24000 µA and floor is 4000 µA for 4 to 20 mA and 0 otherwise; with `drive_en` low `iout_ua` is 0.
- R5: `clear_in` passes SYNC_N synchronizer flops and becomes a qualified clear only after the synchronized level is high for CLR_MIN consecutive clocks; a shorter pulse has no effect on any output.
- R6: A qualified clear sets `target_code` to 0, so `iout_ua` shows the bottom of the selected range.
- R7: A `data_commit` during a qualified clear is discarded and is not applied after release.
- R8: After the clear is released, `target_code` stays 0 until a strobe arrives.
- R9: After release, a `latch_empty` strobe restores the code in force before the clear; `latch_empty` during a qualified clear, or with no clear pending, leaves `target_code` unchanged.
- R10: After release, a `data_commit` installs the new word and ends the cleared state, so a later `latch_empty` does not bring back the pre-clear code.
- R11: If `data_commit` and `latch_empty` arrive in the same cycle after release, the committed word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_in | input | 1 | Asynchronous active-high clear request |
| data_word | input | CODE_W | Committed data register value |
| data_commit | input | 1 | One-cycle strobe: data_word was committed |
| latch_empty | input | 1 | One-cycle strobe: latch edge with no data clocked |
| range_sel | input | 3 | Range selector from the control register |
| out_en | input | 1 | Output-enable bit from the control register |
| target_code | output | CODE_W | Code for the converter core |
| range_code | output | 3 | Registered range for the output stage |
| drive_en | output | 1 | Output stage drives the loop |
| out_hiz | output | 1 | Output stage is high impedance |
| iout_ua | output | 15 | Nominal loop current in microamps |

## Verification
The bound checker watches the clamp to zero during a qualified clear, the frozen pre-clear code, the stability of the target when no strobe arrives, the restore and commit paths, and the range gating and current window, on every clock. Glitch rejection, the exact scaled current for specific codes and ranges, and multi-step sequences (clear, blocked commit, release, restore or override) only show up in the bench's directed scenarios and its random commits, which are compared against a reference model in the bench.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

    localparam int IOUT_W = 15;
    localparam int RNG_W  = 3;

    localparam logic [RNG_W-1:0] RNG_4_20 = 3'b101;
    localparam logic [RNG_W-1:0] RNG_0_20 = 3'b110;
    localparam logic [RNG_W-1:0] RNG_0_24 = 3'b111;

    typedef enum logic [1:0] {
        HOLD_LIVE   = 2'd0,
        HOLD_CLAMP  = 2'd1,
        HOLD_PARKED = 2'd2
    } hold_st_t;

    typedef struct packed {
        logic              valid;
        logic [IOUT_W-1:0] span_ua;
        logic [IOUT_W-1:0] floor_ua;
    } rng_info_t;

    function automatic rng_info_t rng_decode(input logic [RNG_W-1:0] r);
        rng_info_t info;
        info.valid    = 1'b1;
        info.floor_ua = '0;
        unique case (r)
            RNG_4_20: begin
                info.span_ua  = 15'd16000;
                info.floor_ua = 15'd4000;
            end
            RNG_0_20: info.span_ua = 15'd20000;
            RNG_0_24: info.span_ua = 15'd24000;
            default: begin
                info.valid   = 1'b0;
                info.span_ua = '0;
            end
        endcase
        return info;
    endfunction

    function automatic logic rng_valid(input logic [RNG_W-1:0] r);
        rng_info_t info;
        info = rng_decode(r);
        return info.valid;
    endfunction

endpackage

// File: rtl/ltc_clear_filter.sv
module ltc_clear_filter #(
    parameter int SYNC_N  = 2,
    parameter int CLR_MIN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_in,
    output logic clr_act
);
    localparam int CNT_W = $clog2(CLR_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLR_MIN);

    logic [SYNC_N-1:0] sync_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              clr_lvl;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_N; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[gi] <= 1'b0;
                    else     sync_q[gi] <= clear_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[gi] <= 1'b0;
                    else     sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    assign clr_lvl = sync_q[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (!clr_lvl)        cnt_q <= '0;
        else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign clr_act = (cnt_q == CNT_TOP);

endmodule

// File: rtl/ltc_hold_fsm.sv
module ltc_hold_fsm
    import ltc_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_act,
    input  logic [CODE_W-1:0] data_word,
    input  logic              data_commit,
    input  logic              latch_empty,
    output logic [CODE_W-1:0] target_code,
    output logic [CODE_W-1:0] held_code,
    output hold_st_t          hold_st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_st     <= HOLD_LIVE;
            held_code   <= '0;
            target_code <= '0;
        end else begin
            unique case (hold_st)
                HOLD_LIVE: begin
                    if (clr_act) begin
                        hold_st     <= HOLD_CLAMP;
                        target_code <= '0;
                    end else if (data_commit) begin
                        held_code   <= data_word;
                        target_code <= data_word;
                    end
                end
                HOLD_CLAMP: begin
                    target_code <= '0;
                    if (!clr_act) hold_st <= HOLD_PARKED;
                end
                HOLD_PARKED: begin
                    if (clr_act) begin
                        hold_st <= HOLD_CLAMP;
                    end else if (data_commit) begin
                        held_code   <= data_word;
                        target_code <= data_word;
                        hold_st     <= HOLD_LIVE;
                    end else if (latch_empty) begin
                        target_code <= held_code;
                        hold_st     <= HOLD_LIVE;
                    end
                end
                default: begin
                    hold_st     <= HOLD_LIVE;
                    target_code <= held_code;
                end
            endcase
        end
    end

endmodule

// File: rtl/ltc_scale.sv
module ltc_scale
    import ltc_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RNG_W-1:0]  range_sel,
    input  logic              out_en,
    input  logic [CODE_W-1:0] code,
    output logic [RNG_W-1:0]  range_code,
    output logic              drive_en,
    output logic              out_hiz,
    output logic [IOUT_W-1:0] iout_ua
);
    localparam int PROD_W = CODE_W + IOUT_W;

    rng_info_t           info;
    logic                en_q;
    logic [PROD_W-1:0]   prod;
    logic [IOUT_W-1:0]   step_ua;

    always_ff @(posedge clk) begin
        if (rst) begin
            range_code <= '0;
            en_q       <= 1'b0;
        end else begin
            range_code <= range_sel;
            en_q       <= out_en & rng_valid(range_sel);
        end
    end

    always_comb begin
        info    = rng_decode(range_code);
        prod    = {{CODE_W{1'b0}}, info.span_ua} * {{IOUT_W{1'b0}}, code};
        step_ua = prod[PROD_W-1:CODE_W];
        iout_ua = en_q ? (info.floor_ua + step_ua) : '0;
    end

    assign drive_en = en_q;
    assign out_hiz  = ~en_q;

endmodule

// File: rtl/loop_target_ctrl.sv
module loop_target_ctrl
    import ltc_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int SYNC_N  = 2,
    parameter int CLR_MIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_in,
    input  logic [CODE_W-1:0] data_word,
    input  logic              data_commit,
    input  logic              latch_empty,
    input  logic [2:0]        range_sel,
    input  logic              out_en,
    output logic [CODE_W-1:0] target_code,
    output logic [2:0]        range_code,
    output logic              drive_en,
    output logic              out_hiz,
    output logic [14:0]       iout_ua
);
    logic              clr_act;
    logic [CODE_W-1:0] held_code;
    hold_st_t          hold_st;

    ltc_clear_filter #(
        .SYNC_N (SYNC_N),
        .CLR_MIN(CLR_MIN)
    ) u_filt (
        .clk     (clk),
        .rst     (rst),
        .clear_in(clear_in),
        .clr_act (clr_act)
    );

    ltc_hold_fsm #(
        .CODE_W(CODE_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .clr_act    (clr_act),
        .data_word  (data_word),
        .data_commit(data_commit),
        .latch_empty(latch_empty),
        .target_code(target_code),
        .held_code  (held_code),
        .hold_st    (hold_st)
    );

    ltc_scale #(
        .CODE_W(CODE_W)
    ) u_scale (
        .clk       (clk),
        .rst       (rst),
        .range_sel (range_sel),
        .out_en    (out_en),
        .code      (target_code),
        .range_code(range_code),
        .drive_en  (drive_en),
        .out_hiz   (out_hiz),
        .iout_ua   (iout_ua)
    );

endmodule

// File: rtl/ltc_checker.sv
module ltc_checker
    import ltc_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_act,
    input hold_st_t          hold_st,
    input logic [CODE_W-1:0] held_code,
    input logic [CODE_W-1:0] target_code,
    input logic [CODE_W-1:0] data_word,
    input logic              data_commit,
    input logic              latch_empty,
    input logic [2:0]        range_code,
    input logic              drive_en,
    input logic [14:0]       iout_ua
);
    rng_info_t info;
    assign info = rng_decode(range_code);

    assert_clamp_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> (target_code == '0));

    assert_commit_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> (held_code == $past(held_code)));

    assert_no_strobe_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!clr_act && !data_commit && !latch_empty) |=> $stable(target_code));

    assert_restore_R9: assert property (@(posedge clk) disable iff (rst)
        (hold_st == HOLD_PARKED && !clr_act && !data_commit && latch_empty)
        |=> (target_code == $past(held_code)));

    assert_commit_apply_R2: assert property (@(posedge clk) disable iff (rst)
        (hold_st != HOLD_CLAMP && !clr_act && data_commit)
        |=> (target_code == $past(data_word)));

    assert_invalid_off_R3: assert property (@(posedge clk) disable iff (rst)
        !info.valid |-> !drive_en);

    assert_iout_window_R4: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> (iout_ua >= info.floor_ua &&
                      iout_ua < (info.floor_ua + info.span_ua)));

    assert_iout_off_R4: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (iout_ua == '0));

endmodule

bind loop_target_ctrl ltc_checker #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_act    (clr_act),
    .hold_st    (hold_st),
    .held_code  (held_code),
    .target_code(target_code),
    .data_word  (data_word),
    .data_commit(data_commit),
    .latch_empty(latch_empty),
    .range_code (range_code),
    .drive_en   (drive_en),
    .iout_ua    (iout_ua)
);

// File: tb/tb_loop_target_ctrl.sv
`timescale 1ns/1ps
module tb_loop_target_ctrl;
    localparam int CODE_W  = 16;
    localparam int CLR_MIN = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clear_in = 1'b0;
    logic [CODE_W-1:0] data_word = '0;
    logic              data_commit = 1'b0;
    logic              latch_empty = 1'b0;
    logic [2:0]        range_sel = '0;
    logic              out_en = 1'b0;
    logic [CODE_W-1:0] target_code;
    logic [2:0]        range_code;
    logic              drive_en;
    logic              out_hiz;
    logic [14:0]       iout_ua;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    loop_target_ctrl #(.CODE_W(CODE_W), .SYNC_N(2), .CLR_MIN(CLR_MIN)) dut (
        .clk(clk), .rst(rst), .clear_in(clear_in), .data_word(data_word),
        .data_commit(data_commit), .latch_empty(latch_empty),
        .range_sel(range_sel), .out_en(out_en), .target_code(target_code),
        .range_code(range_code), .drive_en(drive_en), .out_hiz(out_hiz),
        .iout_ua(iout_ua)
    );

    function automatic logic m_valid(input logic [2:0] r);
        return (r == 3'b101) || (r == 3'b110) || (r == 3'b111);
    endfunction

    function automatic int m_iout(input logic [2:0] r, input logic en,
                                  input logic [CODE_W-1:0] c);
        longint span;
        longint flr;
        if (!(en && m_valid(r))) return 0;
        span = (r == 3'b101) ? 16000 : (r == 3'b110) ? 20000 : 24000;
        flr  = (r == 3'b101) ? 4000 : 0;
        return int'(flr + ((span * longint'(c)) >>> CODE_W));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        data_commit = 1'b0;
        latch_empty = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic commit(input logic [CODE_W-1:0] w);
        data_word   = w;
        data_commit = 1'b1;
        step();
    endtask

    task automatic strobe_empty();
        latch_empty = 1'b1;
        step();
    endtask

    task automatic clear_hold();
        clear_in = 1'b1;
        wait_n(CLR_MIN + 6);
    endtask

    task automatic clear_release();
        clear_in = 1'b0;
        wait_n(6);
    endtask

    task automatic chk_out(input string req, input logic [CODE_W-1:0] code);
        chk({req, " target"}, int'(target_code), int'(code));
        chk({req, " iout"}, int'(iout_ua), m_iout(range_sel, out_en, code));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [2:0] rr;
        logic [CODE_W-1:0] cur;
        void'($urandom(32'h5EED_C1A0));
        @(negedge clk);
        wait_n(3);
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 target", int'(target_code), 0);
        chk("R1 range", int'(range_code), 0);
        chk("R1 drive_en", int'(drive_en), 0);
        chk("R1 out_hiz", int'(out_hiz), 1);
        chk("R1 iout", int'(iout_ua), 0);

        // R4 corner codes in every valid range
        for (int r = 5; r <= 7; r++) begin
            range_sel = 3'(r);
            out_en    = 1'b1;
            commit(16'hFFFF);
            chk_out("R4 full", 16'hFFFF);
            commit(16'h0000);
            chk_out("R4 zero", 16'h0000);
            commit(16'h8000);
            chk_out("R4 mid", 16'h8000);
        end

        // R3 invalid range keeps output off, enable bit low keeps it off
        range_sel = 3'b011;
        step();
        chk("R3 invalid drive_en", int'(drive_en), 0);
        chk("R3 invalid hiz", int'(out_hiz), 1);
        chk("R3 invalid iout", int'(iout_ua), 0);
        chk("R3 range follows", int'(range_code), 3);
        range_sel = 3'b110;
        out_en    = 1'b0;
        step();
        chk("R3 en low drive_en", int'(drive_en), 0);

        // R2 / R3 / R4 random commits
        for (int i = 0; i < 300; i++) begin
            rr = 3'($urandom_range(0, 9) < 8 ? $urandom_range(5, 7) : $urandom_range(0, 4));
            range_sel = rr;
            out_en    = 1'($urandom_range(0, 3) != 0);
            cur       = CODE_W'($urandom);
            commit(cur);
            chk("R2 random target", int'(target_code), int'(cur));
            chk("R3 random drive_en", int'(drive_en), int'(out_en && m_valid(rr)));
            chk("R3 random hiz", int'(out_hiz), int'(!(out_en && m_valid(rr))));
            chk("R4 random iout", int'(iout_ua), m_iout(rr, out_en, cur));
        end

        // Clear sequence with restore
        range_sel = 3'b110;
        out_en    = 1'b1;
        commit(16'h1234);
        strobe_empty();
        chk("R9 empty strobe no clear", int'(target_code), 16'h1234);
        clear_hold();
        chk_out("R6 clamp 0-20", 16'h0000);
        range_sel = 3'b101;
        step();
        chk("R6 bottom 4-20 iout", int'(iout_ua), 4000);
        commit(16'hBEEF);
        chk("R7 commit during clear", int'(target_code), 0);
        strobe_empty();
        chk("R9 empty during clear", int'(target_code), 0);
        clear_release();
        chk("R8 stays cleared", int'(target_code), 0);
        chk("R8 iout bottom", int'(iout_ua), 4000);
        wait_n(5);
        chk("R8 still cleared", int'(target_code), 0);
        strobe_empty();
        chk("R9 restore pre-clear", int'(target_code), 16'h1234);
        chk("R7 blocked word not applied", int'(target_code != 16'hBEEF), 1);

        // R10 commit after release overrides
        clear_hold();
        clear_release();
        commit(16'h5555);
        chk("R10 new commit", int'(target_code), 16'h5555);
        strobe_empty();
        chk("R10 empty after commit", int'(target_code), 16'h5555);

        // R11 both strobes in one cycle after release
        clear_hold();
        clear_release();
        data_word   = 16'h7777;
        data_commit = 1'b1;
        latch_empty = 1'b1;
        step();
        chk("R11 commit wins", int'(target_code), 16'h7777);

        // R5 short pulse rejected
        clear_in = 1'b1;
        wait_n(CLR_MIN - 2);
        clear_in = 1'b0;
        wait_n(10);
        chk("R5 glitch ignored", int'(target_code), 16'h7777);
        commit(16'h0F0F);
        chk("R5 commit after glitch", int'(target_code), 16'h0F0F);
        // R5 long pulse qualifies
        clear_hold();
        chk("R5 long pulse clears", int'(target_code), 0);
        clear_release();
        strobe_empty();
        chk("R9 restore after long pulse", int'(target_code), 16'h0F0F);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule